// File: doc/BRIEF.md
# Boot ROM Overlay over a Byte RAM Window

This block backs a 256-byte, byte-addressed memory window with RAM and lays a fixed 32-byte boot program over the lowest 32 addresses. When the chip leaves reset with the boot strap asserted, a processor that fetches from address zero reads the boot bytes. The RAM underneath stays fully writable the whole time: the overlay affects reads only, so the boot code can fill the low RAM while it is still running from ROM.

The overlay has no control register. It turns itself off the first time the processor reads any address with bit 5 set, which is what happens when the boot code jumps past its own 32 bytes. From then on the whole window reads as plain RAM until the next reset. Read data is registered. It appears one clock after the edge that samples the address and the read strobe, and it holds its value while no read is made.

Top module: `boot_overlay_mem`

## Requirements
- R1: While reset (rst_n low, synchronous) is applied, rd_data is cleared to 0x00, and the overlay state is loaded from boot_strap (1 = overlay on). RAM contents are not cleared.
- R2: A read of an address below 0x20 while the overlay is on returns the boot byte at that address. The data is on rd_data one clock after the sampling edge. The boot bytes, from address 0x00 upward, are DB FC AF 6F 67 3C D3 FA 3E 8C D3 F8 DB FC B7 F2 19 00 DB FB 77 23 C3 0C 00 DB F8 B7 CA 7D 00 76.
- R3: A read of any address at or above 0x20, and any read while the overlay is off, returns the RAM byte at that address with the same one-clock latency.
- R4: Every write stores wr_data into RAM at addr, including addresses 0x00 to 0x1F while the overlay is on. Such data becomes visible once the overlay is off.
- R5: A read whose address has bit 5 set turns the overlay off from the next clock on. That triggering read itself returns RAM data. The overlay stays off until the next reset.
- R6: A read whose address has bit 5 clear leaves the overlay on, even when the address is at or above 0x40.
- R7: When reset is released with boot_strap low, the overlay is off from the first cycle, so reads below 0x20 return RAM.
- R8: When a read and a write address the same location in one cycle, the read returns the content from before the write (or the boot byte, if the overlay applies). The new value is returned by later reads.
- R9: rd_data holds its value in every cycle in which rd_en is low.
- R10: A write never changes the overlay state, including a write to an address with bit 5 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| boot_strap | input | 1 | Overlay enable, loaded while reset is applied |
| addr | input | 8 | Byte address within the window |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Registered read data, one clock after the read |

## Verification
Two functions can fall in the same cycle here. A read and a write can hit one location together, and a read can trigger the overlay switch-off while that same read is being served. The bench drives both the read and the write strobe in one cycle, at addresses under the ROM and above it, with and without the overlay on, and it also issues trigger reads that carry a write. A reference model in the bench evaluates the read against the state before the cycle and then applies the write and the disable. The result must show the old byte (or the boot byte) on the read, and the written byte and the new overlay state on the reads that follow.

// File: rtl/boot_ovl_pkg.sv
// Package: shared widths and boot image for the boot overlay.
// Assumes the boot image is exactly 2**BOOT_AW bytes placed at address zero.
package boot_ovl_pkg;
    localparam int MEM_AW  = 8;
    localparam int DATA_W  = 8;
    localparam int BOOT_AW = 5;

    // Return one byte of the fixed boot program.
    function automatic logic [DATA_W-1:0] boot_image(input logic [BOOT_AW-1:0] idx);
        logic [DATA_W-1:0] b;
        case (idx)
            5'd0:  b = 8'hDB; 5'd1:  b = 8'hFC; 5'd2:  b = 8'hAF; 5'd3:  b = 8'h6F;
            5'd4:  b = 8'h67; 5'd5:  b = 8'h3C; 5'd6:  b = 8'hD3; 5'd7:  b = 8'hFA;
            5'd8:  b = 8'h3E; 5'd9:  b = 8'h8C; 5'd10: b = 8'hD3; 5'd11: b = 8'hF8;
            5'd12: b = 8'hDB; 5'd13: b = 8'hFC; 5'd14: b = 8'hB7; 5'd15: b = 8'hF2;
            5'd16: b = 8'h19; 5'd17: b = 8'h00; 5'd18: b = 8'hDB; 5'd19: b = 8'hFB;
            5'd20: b = 8'h77; 5'd21: b = 8'h23; 5'd22: b = 8'hC3; 5'd23: b = 8'h0C;
            5'd24: b = 8'h00; 5'd25: b = 8'hDB; 5'd26: b = 8'hF8; 5'd27: b = 8'hB7;
            5'd28: b = 8'hCA; 5'd29: b = 8'h7D; 5'd30: b = 8'h00; default: b = 8'h76;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/boot_ovl_rom.sv
// Module: boot_ovl_rom
// Combinational lookup of the boot image. It assumes the caller only uses
// the result for addresses inside the boot range.
module boot_ovl_rom
    import boot_ovl_pkg::*;
#(
    parameter int AW = BOOT_AW,
    parameter int DW = DATA_W
) (
    input  logic [AW-1:0] idx,
    output logic [DW-1:0] rom_q
);
    // Pick the image byte for the low address bits.
    always_comb begin
        rom_q = DW'(boot_image(BOOT_AW'(idx)));
    end
endmodule

// File: rtl/boot_ovl_ram.sv
// Module: boot_ovl_ram
// Byte RAM with a synchronous write and a combinational read port.
// The read port shows the content before a write in the same cycle.
// Contents are not reset.
module boot_ovl_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] ram_q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store a byte on every write strobe, whatever the overlay state.
    always_ff @(posedge clk) begin
        if (wr_en) mem[addr] <= wr_data;
    end

    // Present the stored byte at the current address.
    always_comb begin
        ram_q = mem[addr];
    end

    // R4: a written byte is found in storage on the next clock.
    p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem[$past(addr)] == $past(wr_data));
endmodule

// File: rtl/boot_ovl_ctrl.sv
// Module: boot_ovl_ctrl
// Keeps the overlay flag and decides whether a read is served by ROM.
// The flag is loaded from the strap during synchronous reset and is cleared
// by a read whose address has bit TRIG_BIT set. It is never set again until reset.
module boot_ovl_ctrl #(
    parameter int AW       = 8,
    parameter int BOOT_W   = 5,
    parameter int TRIG_BIT = BOOT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          boot_strap,
    input  logic [AW-1:0] addr,
    input  logic          rd_en,
    output logic          overlay_on,
    output logic          use_rom
);
    logic in_boot_range;
    logic trigger;

    // Decode the boot range and the trigger read.
    always_comb begin
        in_boot_range = (addr[AW-1:BOOT_W] == '0);
        trigger       = rd_en && addr[TRIG_BIT];
        use_rom       = overlay_on && in_boot_range;
    end

    // Load the flag from the strap at reset; clear it after a trigger read.
    always_ff @(posedge clk) begin
        if (!rst_n)       overlay_on <= boot_strap;
        else if (trigger) overlay_on <= 1'b0;
    end

    // R5: a trigger read switches the overlay off.
    p_trigger_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr[TRIG_BIT]) |=> !overlay_on);
    // R5: once off, it stays off until reset.
    p_stays_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !overlay_on |=> !overlay_on);
    // R6 and R10: no read with bit 5 set means no change.
    p_no_false_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (overlay_on && !(rd_en && addr[TRIG_BIT])) |=> overlay_on);
endmodule

// File: rtl/boot_overlay_mem.sv
// Module: boot_overlay_mem (top)
// A 256-byte RAM window with a 32-byte boot image overlaid on reads of the
// lowest addresses until the first read with address bit 5 set.
// Assumes single-cycle strobes sampled on the rising clock edge. Read data is
// registered and held while no read is made.
module boot_overlay_mem
    import boot_ovl_pkg::*;
#(
    parameter int AW = MEM_AW,
    parameter int DW = DATA_W,
    parameter int BW = BOOT_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          boot_strap,
    input  logic [AW-1:0] addr,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] rom_q;
    logic [DW-1:0] ram_q;
    logic          overlay_on;
    logic          use_rom;

    boot_ovl_rom #(.AW(BW), .DW(DW)) u_rom (
        .idx   (addr[BW-1:0]),
        .rom_q (rom_q)
    );

    boot_ovl_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ram_q   (ram_q)
    );

    boot_ovl_ctrl #(.AW(AW), .BOOT_W(BW), .TRIG_BIT(BW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .boot_strap (boot_strap),
        .addr       (addr),
        .rd_en      (rd_en),
        .overlay_on (overlay_on),
        .use_rom    (use_rom)
    );

    // Register the selected byte on a read; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= use_rom ? rom_q : ram_q;
    end

    // R9: the output holds when no read is made.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
    // R2: a read in the boot range with the overlay on shows the image byte.
    p_rom_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && overlay_on && addr < AW'(1 << BW)) |=> rd_data == $past(rom_q));
    // R3: a read outside the boot range shows the RAM byte.
    p_ram_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr >= AW'(1 << BW)) |=> rd_data == $past(ram_q));
endmodule

// File: tb/boot_overlay_mem_bench.sv
`timescale 1ns/1ps
module boot_overlay_mem_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       boot_strap = 1'b1;
    logic [7:0] addr = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [7:0] model_mem [256];
    bit         model_ovl;
    logic [7:0] exp_rd;

    boot_overlay_mem u_boot_overlay_mem (
        .clk(clk), .rst_n(rst_n), .boot_strap(boot_strap), .addr(addr),
        .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
    );

    always #2 clk = ~clk;

    // Independent copy of the boot image taken from the requirements (R2).
    function automatic logic [7:0] img(input logic [4:0] i);
        logic [7:0] t [32] = '{8'hDB,8'hFC,8'hAF,8'h6F,8'h67,8'h3C,8'hD3,8'hFA,
                               8'h3E,8'h8C,8'hD3,8'hF8,8'hDB,8'hFC,8'hB7,8'hF2,
                               8'h19,8'h00,8'hDB,8'hFB,8'h77,8'h23,8'hC3,8'h0C,
                               8'h00,8'hDB,8'hF8,8'hB7,8'hCA,8'h7D,8'h00,8'h76};
        return t[i];
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: rd_data=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_reset(input bit strap);
        @(negedge clk);
        rst_n = 1'b0; boot_strap = strap; rd_en = 0; wr_en = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        model_ovl = strap;
        exp_rd = 8'h00;
        chk("R1", rd_data, 8'h00);
    endtask

    // One bus cycle; the model evaluates the read before applying write/disable.
    task automatic op(input bit rd, input bit wr, input logic [7:0] a,
                      input logic [7:0] d, input string req);
        rd_en = rd; wr_en = wr; addr = a; wr_data = d;
        if (rd) begin
            exp_rd = (model_ovl && a < 8'h20) ? img(a[4:0]) : model_mem[a];
            if (a[5]) model_ovl = 0;
        end
        if (wr) model_mem[a] = d;
        @(negedge clk);
        rd_en = 0; wr_en = 0;
        chk(req, rd_data, exp_rd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: rd_data=%02h expected=%02h", rd_data, exp_rd);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        do_reset(1'b1);
        // Fill RAM, including the range under the ROM, with the overlay on (R4, R10).
        for (int i = 0; i < 256; i++) op(0, 1, 8'(i), 8'($urandom), "R9");
        // Every boot byte (R2).
        for (int i = 0; i < 32; i++) op(1, 0, 8'(i), 8'h00, "R2");
        op(1, 0, 8'h45, 8'h00, "R3");
        op(1, 0, 8'h03, 8'h00, "R6");          // 0x45 did not disable
        op(1, 0, 8'h9A, 8'h00, "R6");          // bit 5 clear above 0x80
        op(1, 0, 8'h1F, 8'h00, "R6");
        op(0, 1, 8'h20, 8'h5A, "R10");
        op(1, 0, 8'h04, 8'h00, "R10");         // write with bit 5 did not disable
        op(1, 1, 8'h10, 8'hA5, "R8");          // read shows ROM while write lands
        op(1, 0, 8'h3F, 8'h00, "R5");          // trigger read returns RAM
        op(1, 0, 8'h00, 8'h00, "R5");          // overlay now off
        op(1, 0, 8'h10, 8'h00, "R4");          // written under ROM earlier
        op(1, 0, 8'h20, 8'h00, "R3");
        op(1, 1, 8'h80, 8'h3C, "R8");
        op(1, 0, 8'h80, 8'h00, "R8");
        op(0, 0, 8'h11, 8'h00, "R9");
        op(0, 1, 8'h11, 8'hEE, "R9");
        op(1, 0, 8'h1E, 8'h00, "R5");          // still off
        do_reset(1'b0);
        op(1, 0, 8'h00, 8'h00, "R7");
        op(1, 0, 8'h1F, 8'h00, "R7");
        do_reset(1'b1);
        op(1, 0, 8'h02, 8'h00, "R1");          // strap loaded at reset
        op(1, 1, 8'hE0, 8'h77, "R8");          // trigger read with write in same cycle
        op(1, 0, 8'hE0, 8'h00, "R8");
        op(1, 0, 8'h02, 8'h00, "R5");
        // Constrained random phase with occasional resets.
        for (int n = 0; n < 3000; n++) begin
            bit rd, wr;
            logic [7:0] a;
            if (($urandom % 400) == 0) do_reset(1'($urandom));
            rd = ($urandom % 4) != 0;
            wr = ($urandom % 3) == 0;
            a  = (($urandom % 2) == 0) ? 8'($urandom % 32) : 8'($urandom);
            if (rd && wr)      op(rd, wr, a, 8'($urandom), "R8");
            else if (!rd)      op(rd, wr, a, 8'($urandom), "R9");
            else if (model_ovl && a < 8'h20) op(rd, wr, a, 8'h00, "R2");
            else if (model_ovl && a[5])      op(rd, wr, a, 8'h00, "R5");
            else               op(rd, wr, a, 8'h00, "R3");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule